// File: doc/BRIEF.md
# Flash Protected-Range Address Checker

This block sits in the path between a flash cycle engine and the serial shifter. It holds five software-programmed protected ranges and screens every requested flash cycle against them. Each range covers whole 4 KB pages. A range can deny reads, deny writes, or deny both. A denied write also stops erase cycles. A cycle that passes goes on to the shifter unchanged. A cycle that a range denies is dropped, and the checker raises a one-cycle error pulse that the cycle engine reports as its cycle error.

The ranges are set up while the block is unlocked. They have no effect until a sticky lock-down input is pulsed. From then until reset, the range registers refuse all writes and every enabled range is enforced.

Cycle requests enter on a valid/ready stream and leave on a second valid/ready stream, with one register stage between them. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high when the stage is empty, when the stage holds a denied cycle (that cycle leaves on the next edge whatever the downstream does), or when the downstream is taking the held cycle this cycle. An issued cycle stays on `iss_*`, unchanged, until `iss_ready` is seen high.

Top module: `flash_prot_checker`

## Requirements
- R1: There are five range registers, indexed 0 to 4. They reset to zero and read back on `cfg_rd_data` through `cfg_rd_idx`. An index of 5 or above reads as zero, and a write to such an index changes nothing.
- R2: The range register layout is: bit 31 enables write protection, bit 15 enables read protection, bits 28:16 hold the upper page number (address bits 24:12), and bits 12:0 hold the lower page number. Bits 30:29 and 14:13 always read as zero, so a write of all ones reads back as 0x9FFF9FFF.
- R3: A high `lock_set` sets `lock_q` on the next edge, and `lock_q` then stays high until reset. While `lock_q` is high, writes to the range registers are ignored.
- R4: While `lock_q` is low, no cycle is denied, whatever the ranges hold.
- R5: An address is inside a range when lower page × 4096 ≤ address ≤ upper page × 4096 + 4095. A range whose upper page is below its lower page contains no address.
- R6: A read (kind 2'b00) is denied when a range with read protection set contains it. A range with only write protection set never denies a read.
- R7: A program (kind 2'b01) or an erase (kind 2'b10) is denied when a range with write protection set contains it. A range with only read protection set never denies these.
- R8: `req_len` gives the byte count minus one. The last byte address is `req_addr + req_len`. A cycle is tested at its first byte address and at its last byte address, and it is denied if either of the two is denied.
- R9: Kind 2'b11 marks a cycle that carries no flash address. It is never denied.
- R10: A cycle that passes appears on `iss_valid`/`iss_addr`/`iss_kind`/`iss_len` one cycle after it is accepted. It stays there, unchanged, until `iss_ready` is high, and `req_ready` is low while a passed cycle waits.
- R11: A denied cycle raises `blk_err` for exactly one cycle, one cycle after it is accepted. It never appears on `iss_valid`, and it does not wait for `iss_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Range register write strobe |
| cfg_wr_idx | input | 3 | Range register index for the write |
| cfg_wr_data | input | 32 | Range register write value |
| cfg_rd_idx | input | 3 | Range register index for readback |
| cfg_rd_data | output | 32 | Readback value (combinational) |
| lock_set | input | 1 | Sets the sticky lock-down |
| lock_q | output | 1 | Lock-down state |
| req_valid | input | 1 | Cycle request valid |
| req_ready | output | 1 | Checker can take a request |
| req_addr | input | 25 | Cycle first byte address |
| req_kind | input | 2 | 00 read, 01 program, 10 erase, 11 no address |
| req_len | input | 6 | Byte count minus one |
| iss_valid | output | 1 | Passed cycle for the shifter |
| iss_ready | input | 1 | Shifter takes the cycle |
| iss_addr | output | 25 | Passed cycle address |
| iss_kind | output | 2 | Passed cycle kind |
| iss_len | output | 6 | Passed cycle byte count minus one |
| blk_err | output | 1 | One-cycle pulse for a denied cycle |

## Verification
Register readback is combinational, so it is sampled a moment after the index changes. A register write or a lock pulse takes effect on the edge that samples it, so it is checked at the falling edge after that edge. The verdict on a request, either `iss_valid` or `blk_err`, is due exactly one cycle after acceptance. Every request task therefore drives the request at a falling edge, removes it at the next falling edge, and samples both outputs at that same point. It checks one falling edge later that the pulse or the issued cycle has gone. Under back-pressure, the held cycle is sampled over several falling edges to confirm that it stays stable and that `req_ready` stays low.

// File: rtl/flash_prot_pkg.sv
`timescale 1ns/1ps
package flash_prot_pkg;
  // range register layout
  localparam int PR_REG_W   = 32;
  localparam int PR_WPE_BIT = 31;
  localparam int PR_RPE_BIT = 15;
  localparam int PR_HI_LSB  = 16;
  localparam int PR_LO_LSB  = 0;
  localparam logic [PR_REG_W-1:0] PR_WR_MASK = 32'h9FFF_9FFF;

  typedef enum logic [1:0] {
    FK_READ  = 2'b00,
    FK_PROG  = 2'b01,
    FK_ERASE = 2'b10,
    FK_NONE  = 2'b11
  } fkind_e;
endpackage

// File: rtl/fpc_range_bank.sv
`timescale 1ns/1ps
module fpc_range_bank
  import flash_prot_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  parameter int IDX_W      = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [PR_REG_W-1:0]            wr_data,
  input  logic [IDX_W-1:0]               rd_idx,
  input  logic                           lock_set,
  output logic                           lock_q,
  output logic [PR_REG_W-1:0]            rd_data,
  output logic [NUM_RANGES*PR_REG_W-1:0] regs_flat
);
  logic [PR_REG_W-1:0] regs_q [NUM_RANGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lock_q <= 1'b0;
    else if (lock_set) lock_q <= 1'b1;
  end

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[g] <= '0;
      else if (wr_en && !lock_q && (wr_idx == IDX_W'(g)))
        regs_q[g] <= wr_data & PR_WR_MASK;
    end
    assign regs_flat[g*PR_REG_W +: PR_REG_W] = regs_q[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_RANGES; i++)
      if (rd_idx == IDX_W'(i)) rd_data = regs_q[i];
  end
endmodule

// File: rtl/fpc_range_match.sv
`timescale 1ns/1ps
module fpc_range_match
  import flash_prot_pkg::*;
#(
  parameter int ADDR_W     = 25,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [PR_REG_W-1:0] cfg,
  input  logic [ADDR_W-1:0]   first_addr,
  input  logic [ADDR_W-1:0]   last_addr,
  output logic                rd_deny,
  output logic                wr_deny
);
  localparam int PG_W = ADDR_W - PAGE_SHIFT;

  logic [PG_W-1:0] lo_pg, hi_pg, first_pg, last_pg;
  logic            hit_first, hit_last, hit_any;
  logic            unused_bits;

  assign lo_pg    = cfg[PR_LO_LSB +: PG_W];
  assign hi_pg    = cfg[PR_HI_LSB +: PG_W];
  assign first_pg = first_addr[ADDR_W-1:PAGE_SHIFT];
  assign last_pg  = last_addr[ADDR_W-1:PAGE_SHIFT];

  // page compare is equivalent to byte compare with 000/FFF offsets
  assign hit_first = (first_pg >= lo_pg) && (first_pg <= hi_pg);
  assign hit_last  = (last_pg  >= lo_pg) && (last_pg  <= hi_pg);
  assign hit_any   = hit_first || hit_last;

  assign rd_deny = cfg[PR_RPE_BIT] && hit_any;
  assign wr_deny = cfg[PR_WPE_BIT] && hit_any;

  assign unused_bits = ^{cfg, first_addr[PAGE_SHIFT-1:0], last_addr[PAGE_SHIFT-1:0]};
endmodule

// File: rtl/fpc_cycle_stage.sv
`timescale 1ns/1ps
module fpc_cycle_stage #(
  parameter int ADDR_W = 25,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_deny,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [1:0]        iss_kind,
  output logic [LEN_W-1:0]  iss_len,
  output logic              blk_err
);
  logic full_q, deny_q, accept, leave;

  assign req_ready = !full_q || deny_q || iss_ready;
  assign accept    = req_valid && req_ready;
  assign leave     = full_q && (deny_q || iss_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      deny_q <= 1'b0;
    end else if (accept) begin
      full_q <= 1'b1;
      deny_q <= req_deny;
    end else if (leave) begin
      full_q <= 1'b0;
      deny_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_addr <= '0;
      iss_kind <= '0;
      iss_len  <= '0;
    end else if (accept) begin
      iss_addr <= req_addr;
      iss_kind <= req_kind;
      iss_len  <= req_len;
    end
  end

  assign iss_valid = full_q && !deny_q;
  assign blk_err   = full_q && deny_q;
endmodule

// File: rtl/flash_prot_checker.sv
`timescale 1ns/1ps
module flash_prot_checker
  import flash_prot_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  parameter int IDX_W      = $clog2(NUM_RANGES),
  parameter int ADDR_W     = 25,
  parameter int PAGE_SHIFT = 12,
  parameter int LEN_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [IDX_W-1:0]  cfg_wr_idx,
  input  logic [31:0]       cfg_wr_data,
  input  logic [IDX_W-1:0]  cfg_rd_idx,
  output logic [31:0]       cfg_rd_data,
  input  logic              lock_set,
  output logic              lock_q,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [LEN_W-1:0]  req_len,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [1:0]        iss_kind,
  output logic [LEN_W-1:0]  iss_len,
  output logic              blk_err
);
  logic [NUM_RANGES*PR_REG_W-1:0] regs_flat;
  logic [NUM_RANGES-1:0]          rd_deny_v, wr_deny_v;
  logic [ADDR_W-1:0]              last_addr;
  logic                           deny_now;
  fkind_e                         kind;

  fpc_range_bank #(.NUM_RANGES(NUM_RANGES), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_idx(cfg_wr_idx), .wr_data(cfg_wr_data),
    .rd_idx(cfg_rd_idx), .lock_set(lock_set),
    .lock_q(lock_q), .rd_data(cfg_rd_data), .regs_flat(regs_flat)
  );

  assign last_addr = req_addr + {{(ADDR_W-LEN_W){1'b0}}, req_len};

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_match
    fpc_range_match #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_match (
      .cfg(regs_flat[g*PR_REG_W +: PR_REG_W]),
      .first_addr(req_addr), .last_addr(last_addr),
      .rd_deny(rd_deny_v[g]), .wr_deny(wr_deny_v[g])
    );
  end

  always_comb begin
    kind     = fkind_e'(req_kind);
    deny_now = 1'b0;
    if (lock_q) begin
      unique case (kind)
        FK_READ:           deny_now = |rd_deny_v;
        FK_PROG, FK_ERASE: deny_now = |wr_deny_v;
        default:           deny_now = 1'b0;
      endcase
    end
  end

  fpc_cycle_stage #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .req_len(req_len),
    .req_deny(deny_now),
    .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_addr(iss_addr), .iss_kind(iss_kind), .iss_len(iss_len),
    .blk_err(blk_err)
  );
endmodule

// File: rtl/flash_prot_sva.sv
`timescale 1ns/1ps
module flash_prot_sva #(
  parameter int NUM_RANGES = 5,
  parameter int ADDR_W     = 25,
  parameter int LEN_W      = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lock_q,
  input logic [NUM_RANGES*32-1:0] regs_flat,
  input logic [31:0]            cfg_rd_data,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [1:0]             req_kind,
  input logic                   iss_valid,
  input logic                   iss_ready,
  input logic [ADDR_W-1:0]      iss_addr,
  input logic [1:0]             iss_kind,
  input logic [LEN_W-1:0]       iss_len,
  input logic                   blk_err
);
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q); // R3

  AST_REGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(regs_flat)); // R3

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data[30:29] == 2'b00) && (cfg_rd_data[14:13] == 2'b00)); // R2

  AST_UNLOCKED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |=> !blk_err); // R4

  AST_NONE_KIND_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == 2'b11) |=> !blk_err); // R9

  AST_ISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=>
      (iss_valid && $stable(iss_addr) && $stable(iss_kind) && $stable(iss_len))); // R10

  AST_ACCEPT_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (iss_valid || blk_err)); // R10

  AST_ERR_NOT_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    blk_err |-> (!iss_valid && req_ready)); // R11
endmodule

bind flash_prot_checker flash_prot_sva #(
  .NUM_RANGES(NUM_RANGES), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .lock_q(lock_q), .regs_flat(regs_flat),
  .cfg_rd_data(cfg_rd_data), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_addr(iss_addr), .iss_kind(iss_kind), .iss_len(iss_len),
  .blk_err(blk_err)
);

// File: tb/tb_flash_prot_checker.sv
`timescale 1ns/1ps
module tb_flash_prot_checker;
  localparam logic [1:0] K_RD = 2'b00, K_PG = 2'b01, K_ER = 2'b10, K_NA = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [2:0]  cfg_wr_idx = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [2:0]  cfg_rd_idx = '0;
  logic [31:0] cfg_rd_data;
  logic        lock_set = 1'b0;
  logic        lock_q;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [24:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic [5:0]  req_len = '0;
  logic        iss_valid;
  logic        iss_ready = 1'b1;
  logic [24:0] iss_addr;
  logic [1:0]  iss_kind;
  logic [5:0]  iss_len;
  logic        blk_err;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  flash_prot_checker dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
    .lock_set(lock_set), .lock_q(lock_q),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .req_len(req_len),
    .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_addr(iss_addr), .iss_kind(iss_kind), .iss_len(iss_len),
    .blk_err(blk_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_idx = idx; cfg_wr_data = val;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic reg_check(input string req, input logic [2:0] idx, input logic [31:0] exp);
    cfg_rd_idx = idx;
    #0.5;
    chk(req, $sformatf("readback idx %0d", idx), cfg_rd_data, exp);
  endtask

  // one request with the shifter always ready; verdict due one cycle later
  task automatic do_req(input string req, input logic [24:0] a, input logic [1:0] k,
                        input logic [5:0] l, input bit exp_deny);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_kind = k; req_len = l;
    chk(req, "req_ready before accept", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, $sformatf("blk_err for %h", a), 32'(blk_err), 32'(exp_deny));
    chk(req, $sformatf("iss_valid for %h", a), 32'(iss_valid), 32'(!exp_deny));
    if (!exp_deny) chk(req, "iss_addr", 32'(iss_addr), 32'(a));
    @(negedge clk);
    chk(req, "blk_err one cycle only", 32'(blk_err), 32'd0);
    chk(req, "iss_valid released", 32'(iss_valid), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1", "lock_q after reset", 32'(lock_q), 32'd0);
    chk("R10", "iss_valid after reset", 32'(iss_valid), 32'd0);
    chk("R11", "blk_err after reset", 32'(blk_err), 32'd0);
    chk("R10", "req_ready after reset", 32'(req_ready), 32'd1);
    for (int i = 0; i < 8; i++) reg_check("R1", 3'(i), 32'd0);
  endtask

  task automatic t_layout;
    reg_write(3'd4, 32'hFFFF_FFFF);
    reg_check("R2", 3'd4, 32'h9FFF_9FFF);
    reg_write(3'd5, 32'h1234_5678);
    reg_check("R1", 3'd5, 32'd0);
    for (int i = 0; i < 4; i++) reg_check("R1", 3'(i), 32'd0);
    reg_write(3'd0, 32'h8012_0010); // WP, pages 0x010..0x012
    reg_write(3'd1, 32'h0100_8100); // RP, page 0x100
    reg_write(3'd2, 32'h8020_8030); // both, hi < lo
    reg_check("R2", 3'd0, 32'h8012_0010);
  endtask

  task automatic t_unlocked;
    do_req("R4", 25'h001_0000, K_PG, 6'd0, 1'b0);
    do_req("R4", 25'h010_0000, K_RD, 6'd0, 1'b0);
    do_req("R4", 25'h1FF_F000, K_ER, 6'd0, 1'b0);
  endtask

  task automatic t_lock;
    @(negedge clk); lock_set = 1'b1;
    @(negedge clk); lock_set = 1'b0;
    chk("R3", "lock_q set", 32'(lock_q), 32'd1);
    reg_write(3'd0, 32'h0000_0000);
    reg_check("R3", 3'd0, 32'h8012_0010);
    repeat (3) @(negedge clk);
    chk("R3", "lock_q sticky", 32'(lock_q), 32'd1);
  endtask

  task automatic t_bounds;
    do_req("R5", 25'h000_FFFF, K_PG, 6'd0, 1'b0);
    do_req("R5", 25'h001_0000, K_PG, 6'd0, 1'b1);
    do_req("R5", 25'h001_2FFF, K_PG, 6'd0, 1'b1);
    do_req("R5", 25'h001_3000, K_PG, 6'd0, 1'b0);
    do_req("R5", 25'h002_5000, K_PG, 6'd0, 1'b0); // inverted range
    do_req("R5", 25'h003_0000, K_RD, 6'd0, 1'b0);
    do_req("R5", 25'h1FF_F000, K_RD, 6'd0, 1'b1); // top page
    do_req("R5", 25'h1FF_EFFF, K_PG, 6'd0, 1'b0);
  endtask

  task automatic t_kinds;
    do_req("R6", 25'h010_0800, K_RD, 6'd0, 1'b1);
    do_req("R6", 25'h001_1000, K_RD, 6'd0, 1'b0);
    do_req("R7", 25'h001_1000, K_ER, 6'd0, 1'b1);
    do_req("R7", 25'h010_0000, K_PG, 6'd0, 1'b0);
    do_req("R7", 25'h010_0000, K_ER, 6'd0, 1'b0);
    do_req("R9", 25'h001_0000, K_NA, 6'd0, 1'b0);
    do_req("R9", 25'h1FF_F000, K_NA, 6'd63, 1'b0);
  endtask

  task automatic t_span;
    do_req("R8", 25'h000_FFF0, K_PG, 6'h1F, 1'b1);
    do_req("R8", 25'h00F_FFF0, K_RD, 6'h0F, 1'b0);
    do_req("R8", 25'h00F_FFF0, K_RD, 6'h10, 1'b1);
    do_req("R8", 25'h001_2FF0, K_ER, 6'h3F, 1'b1);
  endtask

  task automatic t_backpressure;
    iss_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 25'h020_0000; req_kind = K_PG; req_len = 6'd7;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "held iss_valid", 32'(iss_valid), 32'd1);
    chk("R10", "req_ready low while held", 32'(req_ready), 32'd0);
    repeat (2) @(negedge clk);
    chk("R10", "still held", 32'(iss_valid), 32'd1);
    chk("R10", "held addr", 32'(iss_addr), 32'h020_0000);
    chk("R10", "held len", 32'(iss_len), 32'd7);
    chk("R10", "held kind", 32'(iss_kind), 32'(K_PG));
    iss_ready = 1'b1;
    #0.5;
    chk("R10", "req_ready with iss_ready", 32'(req_ready), 32'd1);
    @(negedge clk);
    chk("R10", "released", 32'(iss_valid), 32'd0);
    // a denied cycle does not wait for the shifter
    iss_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 25'h001_1000; req_kind = K_PG; req_len = 6'd0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11", "blk_err under back-pressure", 32'(blk_err), 32'd1);
    chk("R11", "no issue under back-pressure", 32'(iss_valid), 32'd0);
    chk("R11", "req_ready while denied", 32'(req_ready), 32'd1);
    @(negedge clk);
    chk("R11", "blk_err dropped", 32'(blk_err), 32'd0);
    iss_ready = 1'b1;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_unlocked();
    t_lock();
    t_bounds();
    t_kinds();
    t_span();
    t_backpressure();
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule